// File: doc/BRIEF.md
# Display Link Training Sequencer

This block runs the two-phase training procedure of a multi-lane serial display link. Clock recovery runs first with training pattern 1. Channel equalisation follows with training pattern 2. Each iteration has the same steps. The block drives the transmitter with the current swing and pre-emphasis codes and writes the pattern and drive settings to the sink. It waits a fixed number of cycles and reads the six link-status bytes back. It then decides whether the phase passed, failed, or needs new drive settings, which it takes from the sink's adjust requests.

All sink register traffic goes through an abstract request/response port, so the bus transport that carries these accesses sits outside the block. A request is held until a single-cycle response arrives. The response's ok flag reports transport success, and for status reads it carries the six status bytes. When training ends, the transmitter returns to normal output and a final request turns the sink's training pattern off. The block then pulses `done` and holds the per-phase result bits and the final drive codes until the next start.

Top module: `link_train_seq`

## Requirements
- R1: After reset the block is idle: `busy`=0, `txPattern`=0 (off), `txSwing`=0, `txPreEmph`=0, `crOk`=0, `eqOk`=0, `reqValid`=0.
- R2: A `start` pulse while idle zeroes all drive settings, clears both result bits and enters clock recovery. Every settings write is a request of kind 0 that carries the phase pattern on `reqPattern` (1 = clock recovery, 2 = equalisation), the same value is driven on `txPattern`, and `reqDrive` carries swing in bits [1:0], the max-swing flag in bit 2, pre-emphasis in bits [4:3] and the max-pre-emphasis flag in bit 5.
- R3: Status byte n sits at `rspStatus[8n+7:8n]`. Lane L's status nibble is in byte L/2, with odd lanes in the upper nibble. Clock recovery passes when nibble bit 0 (clock recovered) is set for every active lane.
- R4: Equalisation passes only when bit 0 of byte 2 (lanes aligned) is set and every active lane has nibble bits 0, 1 and 2 (clock recovered, equalised, symbol locked) all set.
- R5: The adjust request for lane L is in byte 4+L/2, with the lower nibble for even lanes and the upper nibble for odd lanes: swing in nibble bits [1:0], pre-emphasis in [3:2]. New settings are the largest requested swing and the largest requested pre-emphasis over the active lanes.
- R6: A requested swing of 2 or more is applied as 2, with the max-swing flag set.
- R7: Pre-emphasis is capped at 2 for swing 0 or 1, at 1 for swing 2 and at 0 for swing 3. The max-pre-emphasis flag is set whenever the request reaches the cap.
- R8: Clock recovery fails, without a further attempt, when a status read shows no pass while the applied settings already carry the max-swing flag.
- R9: Clock recovery fails when the adjusted swing equals the swing already applied on 5 consecutive adjustments.
- R10: Equalisation performs at most 7 status reads. After the 7th read without a pass, the phase fails.
- R11: The status read request is raised exactly CR_WAIT clock cycles (clock recovery) or EQ_WAIT cycles (equalisation) after the settings-write response is accepted.
- R12: A response with `rspOk`=0 to a settings write or status read aborts the current phase. A phase that does not pass leaves its result bit 0, and a failed or aborted clock recovery skips equalisation.
- R13: At the end, `txPattern` returns to 0 and one request of kind 2 (pattern off) is issued. When its response arrives, `done` pulses for one cycle with `busy` low. `crOk`, `eqOk` and the final drive codes then stay constant while idle.
- R14: `laneCount` selects 1, 2 or 4 active lanes, and any other value acts as 4. Status and adjust fields of inactive lanes have no effect. Status reads are requests of kind 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a training run (taken when idle) |
| laneCount | input | 3 | Active lane count: 1, 2 or 4 |
| reqValid | output | 1 | Sink access request pending |
| reqKind | output | 2 | 0 settings write, 1 status read, 2 pattern off |
| reqPattern | output | 2 | Pattern to write to the sink |
| reqDrive | output | 8 | Drive settings byte for all lanes |
| rspValid | input | 1 | Single-cycle response strobe |
| rspOk | input | 1 | Access succeeded |
| rspStatus | input | 48 | Six link-status bytes, byte 0 lowest |
| txPattern | output | 2 | Transmitter pattern: 0 off, 1, 2 |
| txSwing | output | 2 | Transmitter voltage swing code |
| txPreEmph | output | 2 | Transmitter pre-emphasis code |
| busy | output | 1 | Training in progress |
| done | output | 1 | One-cycle end-of-training pulse |
| crOk | output | 1 | Clock recovery passed |
| eqOk | output | 1 | Equalisation passed |

## Verification
The bench plays a scripted sink that sets the clock-recovery and equalisation flags after a chosen number of reads and returns fixed per-lane adjust requests. A sweep over all sixteen swing/pre-emphasis requests on an odd lane checks the clamping and cap arithmetic, as well as the nibble placement. Requests of swing 1 and swing 0 that never converge give different read counts, so the same-swing stop can be told apart from the max-swing stop. A lane that never recovers is made active and then inactive, which shows whether the lane mask is applied. Injected read and write failures in each phase, together with a never-converging equalisation, test the abort paths and the attempt limit. The measured gap between write and read tests the two waits.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int MAX_LANES    = 4;
  localparam int STATUS_BYTES = 6;
  localparam int STATUS_W     = STATUS_BYTES * 8;
  localparam int ALIGN_BIT    = 16;
  localparam int ADJ_BYTE0    = 4;
  localparam logic [1:0] SWING_CAP = 2'd2;

  localparam logic [1:0] KIND_TRAIN   = 2'd0;
  localparam logic [1:0] KIND_STATUS  = 2'd1;
  localparam logic [1:0] KIND_PAT_OFF = 2'd2;

  localparam logic [1:0] PAT_OFF = 2'd0;
  localparam logic [1:0] PAT_CR  = 2'd1;
  localparam logic [1:0] PAT_EQ  = 2'd2;

  typedef struct packed {
    logic initDrive;
    logic applyAdjust;
    logic ldWaitCr;
    logic ldWaitEq;
    logic decWait;
    logic clrTries;
    logic incTries;
    logic setCr;
    logic setEq;
  } dpStrobe_t;

  function automatic logic [1:0] preLimit(input logic [1:0] sw);
    if (sw <= 2'd1)      return 2'd2;
    else if (sw == 2'd2) return 2'd1;
    else                 return 2'd0;
  endfunction
endpackage

// File: rtl/lt_datapath.sv
module lt_datapath
  import lt_pkg::*;
#(
  parameter int CR_WAIT      = 100,
  parameter int EQ_WAIT      = 400,
  parameter int SAME_LIMIT   = 5,
  parameter int EQ_TRY_LIMIT = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           stb,
  input  logic [2:0]          laneCount,
  input  logic [STATUS_W-1:0] status,
  output logic [1:0]          swing,
  output logic [1:0]          preEmph,
  output logic                maxSwing,
  output logic                maxPre,
  output logic                crPass,
  output logic                eqPass,
  output logic                sameHit,
  output logic                triesOver,
  output logic                waitLast,
  output logic                crOk,
  output logic                eqOk
);
  localparam int WAIT_MAX = (CR_WAIT > EQ_WAIT) ? CR_WAIT : EQ_WAIT;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam int SAME_W   = $clog2(SAME_LIMIT + 1);
  localparam int TRY_W    = $clog2(EQ_TRY_LIMIT + 2);

  logic [MAX_LANES-1:0] activeMask;
  logic [MAX_LANES-1:0] crLane, eqLane;
  logic [2:0]           laneSt [MAX_LANES];
  logic [1:0]           reqSw  [MAX_LANES];
  logic [1:0]           reqPe  [MAX_LANES];
  logic [1:0]           maxReqSw, maxReqPe, newSw, newPe, peLim;
  logic                 newMs, newMp;
  logic [SAME_W-1:0]    sameCnt;
  logic [TRY_W-1:0]     tries;
  logic [WAIT_W-1:0]    waitCnt;
  logic                 unusedStatus;

  assign unusedStatus = ^{status[31:17], status[15], status[11], status[7], status[3]};

  always_comb begin
    case (laneCount)
      3'd1:    activeMask = 4'b0001;
      3'd2:    activeMask = 4'b0011;
      default: activeMask = 4'b1111;
    endcase
  end

  for (genvar g = 0; g < MAX_LANES; g++) begin : gLane
    localparam int SB = 8 * (g / 2) + 4 * (g % 2);
    localparam int AB = 8 * (ADJ_BYTE0 + g / 2) + 4 * (g % 2);
    assign laneSt[g] = status[SB +: 3];
    assign reqSw[g]  = status[AB +: 2];
    assign reqPe[g]  = status[AB + 2 +: 2];
    assign crLane[g] = !activeMask[g] || laneSt[g][0];
    assign eqLane[g] = !activeMask[g] || (&laneSt[g]);
  end

  assign crPass = &crLane;
  assign eqPass = status[ALIGN_BIT] && (&eqLane);

  always_comb begin
    maxReqSw = 2'd0;
    maxReqPe = 2'd0;
    for (int i = 0; i < MAX_LANES; i++) begin
      if (activeMask[i]) begin
        if (reqSw[i] > maxReqSw) maxReqSw = reqSw[i];
        if (reqPe[i] > maxReqPe) maxReqPe = reqPe[i];
      end
    end
    newMs = (maxReqSw >= SWING_CAP);
    newSw = newMs ? SWING_CAP : maxReqSw;
    peLim = preLimit(newSw);
    newMp = (maxReqPe >= peLim);
    newPe = newMp ? peLim : maxReqPe;
  end

  assign sameHit   = (newSw == swing) && (sameCnt == SAME_W'(SAME_LIMIT - 1));
  assign triesOver = tries > TRY_W'(EQ_TRY_LIMIT);
  assign waitLast  = waitCnt == WAIT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swing <= '0; preEmph <= '0; maxSwing <= 1'b0; maxPre <= 1'b0;
      sameCnt <= '0;
    end else if (stb.initDrive) begin
      swing <= '0; preEmph <= '0; maxSwing <= 1'b0; maxPre <= 1'b0;
      sameCnt <= '0;
    end else if (stb.applyAdjust) begin
      swing    <= newSw;
      preEmph  <= newPe;
      maxSwing <= newMs;
      maxPre   <= newMp;
      sameCnt  <= (newSw == swing) ? sameCnt + SAME_W'(1) : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.initDrive || stb.clrTries) tries <= '0;
    else if (stb.incTries)                      tries <= tries + TRY_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)             waitCnt <= '0;
    else if (stb.ldWaitCr) waitCnt <= WAIT_W'(CR_WAIT);
    else if (stb.ldWaitEq) waitCnt <= WAIT_W'(EQ_WAIT);
    else if (stb.decWait)  waitCnt <= waitCnt - WAIT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.initDrive) begin
      crOk <= 1'b0;
      eqOk <= 1'b0;
    end else begin
      if (stb.setCr) crOk <= 1'b1;
      if (stb.setEq) eqOk <= 1'b1;
    end
  end
endmodule

// File: rtl/lt_control.sv
module lt_control
  import lt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       rspValid,
  input  logic       rspOk,
  input  logic       crPass,
  input  logic       eqPass,
  input  logic       sameHit,
  input  logic       triesOver,
  input  logic       waitLast,
  input  logic       maxSwing,
  output dpStrobe_t  stb,
  output logic       reqValid,
  output logic [1:0] reqKind,
  output logic [1:0] reqPattern,
  output logic [1:0] txPattern,
  output logic       busy,
  output logic       done
);
  typedef enum logic [2:0] {S_IDLE, S_WRITE, S_WAIT, S_READ, S_OFF} state_e;

  state_e state, nxt;
  logic   phaseEq, goEq;

  always_comb begin
    stb  = '0;
    nxt  = state;
    goEq = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        stb.initDrive = 1'b1;
        nxt = S_WRITE;
      end
      S_WRITE: if (rspValid) begin
        if (rspOk) begin
          stb.ldWaitCr = !phaseEq;
          stb.ldWaitEq = phaseEq;
          nxt = S_WAIT;
        end else begin
          nxt = S_OFF;
        end
      end
      S_WAIT: begin
        if (waitLast) nxt = S_READ;
        else          stb.decWait = 1'b1;
      end
      S_READ: if (rspValid) begin
        if (!rspOk) begin
          nxt = S_OFF;
        end else if (!phaseEq) begin
          if (crPass) begin
            stb.setCr    = 1'b1;
            stb.clrTries = 1'b1;
            goEq = 1'b1;
            nxt  = S_WRITE;
          end else if (maxSwing) begin
            nxt = S_OFF;
          end else begin
            stb.applyAdjust = 1'b1;
            nxt = sameHit ? S_OFF : S_WRITE;
          end
        end else begin
          if (eqPass) begin
            stb.setEq = 1'b1;
            nxt = S_OFF;
          end else if (triesOver) begin
            nxt = S_OFF;
          end else begin
            stb.applyAdjust = 1'b1;
            stb.incTries    = 1'b1;
            nxt = S_WRITE;
          end
        end
      end
      S_OFF: if (rspValid) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      phaseEq <= 1'b0;
      done    <= 1'b0;
    end else begin
      state <= nxt;
      done  <= (state == S_OFF) && rspValid;
      if (state == S_IDLE && start) phaseEq <= 1'b0;
      else if (goEq)                phaseEq <= 1'b1;
    end
  end

  assign busy       = state != S_IDLE;
  assign reqValid   = (state == S_WRITE) || (state == S_READ) || (state == S_OFF);
  assign reqKind    = (state == S_READ) ? KIND_STATUS :
                      (state == S_OFF)  ? KIND_PAT_OFF : KIND_TRAIN;
  assign txPattern  = (busy && state != S_OFF) ? (phaseEq ? PAT_EQ : PAT_CR) : PAT_OFF;
  assign reqPattern = txPattern;
endmodule

// File: rtl/link_train_seq.sv
module link_train_seq
  import lt_pkg::*;
#(
  parameter int CR_WAIT      = 100,
  parameter int EQ_WAIT      = 400,
  parameter int SAME_LIMIT   = 5,
  parameter int EQ_TRY_LIMIT = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [2:0]  laneCount,
  output logic        reqValid,
  output logic [1:0]  reqKind,
  output logic [1:0]  reqPattern,
  output logic [7:0]  reqDrive,
  input  logic        rspValid,
  input  logic        rspOk,
  input  logic [47:0] rspStatus,
  output logic [1:0]  txPattern,
  output logic [1:0]  txSwing,
  output logic [1:0]  txPreEmph,
  output logic        busy,
  output logic        done,
  output logic        crOk,
  output logic        eqOk
);
  dpStrobe_t stb;
  logic crPass, eqPass, sameHit, triesOver, waitLast, maxSwing, maxPre;

  lt_control uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .rspValid(rspValid), .rspOk(rspOk),
    .crPass(crPass), .eqPass(eqPass), .sameHit(sameHit), .triesOver(triesOver),
    .waitLast(waitLast), .maxSwing(maxSwing), .stb(stb), .reqValid(reqValid),
    .reqKind(reqKind), .reqPattern(reqPattern), .txPattern(txPattern),
    .busy(busy), .done(done)
  );

  lt_datapath #(
    .CR_WAIT(CR_WAIT), .EQ_WAIT(EQ_WAIT),
    .SAME_LIMIT(SAME_LIMIT), .EQ_TRY_LIMIT(EQ_TRY_LIMIT)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .laneCount(laneCount), .status(rspStatus),
    .swing(txSwing), .preEmph(txPreEmph), .maxSwing(maxSwing), .maxPre(maxPre),
    .crPass(crPass), .eqPass(eqPass), .sameHit(sameHit), .triesOver(triesOver),
    .waitLast(waitLast), .crOk(crOk), .eqOk(eqOk)
  );

  assign reqDrive = {2'b00, maxPre, txPreEmph, maxSwing, txSwing};
endmodule

// File: rtl/lt_checker.sv
module lt_checker
  import lt_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       reqValid,
  input logic [1:0] reqKind,
  input logic [1:0] reqPattern,
  input logic       rspValid,
  input logic [1:0] txPattern,
  input logic [1:0] txSwing,
  input logic [1:0] txPreEmph,
  input logic       busy,
  input logic       crOk,
  input logic       eqOk
);
  p_swing_cap_r6: assert property (@(posedge clk) disable iff (!rstN)
    txSwing != 2'd3);

  p_pre_cap_r7: assert property (@(posedge clk) disable iff (!rstN)
    txPreEmph <= preLimit(txSwing));

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !rspValid) |=> (reqValid && $stable(reqKind)));

  p_write_pattern_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == KIND_TRAIN) |-> (reqPattern == txPattern && txPattern != PAT_OFF));

  p_start_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (txSwing == 2'd0 && txPreEmph == 2'd0 && !crOk));

  p_idle_off_r13: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (txPattern == PAT_OFF && !reqValid));

  p_eq_after_cr_r12: assert property (@(posedge clk) disable iff (!rstN)
    eqOk |-> crOk);
endmodule

bind link_train_seq lt_checker uChk (
  .clk(clk), .rstN(rstN), .start(start), .reqValid(reqValid), .reqKind(reqKind),
  .reqPattern(reqPattern), .rspValid(rspValid), .txPattern(txPattern),
  .txSwing(txSwing), .txPreEmph(txPreEmph), .busy(busy), .crOk(crOk), .eqOk(eqOk)
);

// File: tb/link_train_seq_test.sv
module link_train_seq_test;
  localparam int CRW = 6;
  localparam int EQW = 15;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  laneCount = 3'd4;
  logic        reqValid;
  logic [1:0]  reqKind, reqPattern;
  logic [7:0]  reqDrive;
  logic        rspValid = 1'b0;
  logic        rspOk = 1'b0;
  logic [47:0] rspStatus = '0;
  logic [1:0]  txPattern, txSwing, txPreEmph;
  logic        busy, done, crOk, eqOk;

  int checks = 0;
  int errors = 0;

  link_train_seq #(.CR_WAIT(CRW), .EQ_WAIT(EQW)) uut (
    .clk(clk), .rstN(rstN), .start(start), .laneCount(laneCount),
    .reqValid(reqValid), .reqKind(reqKind), .reqPattern(reqPattern), .reqDrive(reqDrive),
    .rspValid(rspValid), .rspOk(rspOk), .rspStatus(rspStatus),
    .txPattern(txPattern), .txSwing(txSwing), .txPreEmph(txPreEmph),
    .busy(busy), .done(done), .crOk(crOk), .eqOk(eqOk)
  );

  always #5 clk = ~clk;

  // scripted sink
  int crPassAfter, eqPassAfter, failReadAt, failWriteAt;
  logic [3:0] stuck;
  logic [1:0] reqV [4];
  logic [1:0] reqP [4];
  int nWrites, nReads, crReads, eqReads, nOff, cyc, lastWr, gapCr, gapEq;
  logic [1:0] sinkPat;
  logic [7:0] wDrive [64];
  logic [1:0] wPat [64];

  always @(negedge clk) begin
    cyc++;
    if (rspValid) begin
      rspValid = 1'b0;
    end else if (reqValid) begin
      rspValid = 1'b1;
      rspOk = 1'b1;
      if (reqKind == 2'd0) begin
        rspOk = (nWrites != failWriteAt);
        if (nWrites < 64) begin
          wDrive[nWrites] = reqDrive;
          wPat[nWrites] = reqPattern;
        end
        nWrites++;
        sinkPat = reqPattern;
        lastWr = cyc;
      end else if (reqKind == 2'd1) begin
        rspOk = (nReads != failReadAt);
        rspStatus = '0;
        for (int l = 0; l < 4; l++) begin
          logic [3:0] nib;
          if (sinkPat == 2'd1) nib = (crReads >= crPassAfter && !stuck[l]) ? 4'h1 : 4'h0;
          else                 nib = (eqReads >= eqPassAfter) ? 4'h7 : 4'h1;
          rspStatus[8*(l/2) + 4*(l%2) +: 4] = nib;
          rspStatus[32 + 8*(l/2) + 4*(l%2) +: 4] = {reqP[l], reqV[l]};
        end
        rspStatus[16] = (sinkPat == 2'd2) && (eqReads >= eqPassAfter);
        if (sinkPat == 2'd1) begin
          gapCr = cyc - lastWr;
          crReads++;
        end else begin
          gapEq = cyc - lastWr;
          eqReads++;
        end
        nReads++;
      end else begin
        nOff++;
        sinkPat = 2'd0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic sinkDefaults();
    crPassAfter = 0; eqPassAfter = 0; failReadAt = -1; failWriteAt = -1;
    stuck = 4'b0;
    for (int l = 0; l < 4; l++) begin reqV[l] = 2'd0; reqP[l] = 2'd0; end
  endtask

  task automatic runTrain(input int lc);
    int n;
    laneCount = 3'(lc);
    nWrites = 0; nReads = 0; crReads = 0; eqReads = 0; nOff = 0; sinkPat = 2'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 5000, "R13 done reached", n, 5000);
    chk(!busy && txPattern == 2'd0 && nOff == 1, "R13 end state", nOff, 1);
  endtask

  // expected drive byte for a request (arithmetic model of R6/R7)
  function automatic int expDrive(input int v, input int p);
    int vv, ms, lim, pp, mp;
    ms = (v >= 2); vv = ms ? 2 : v;
    lim = (vv <= 1) ? 2 : ((vv == 2) ? 1 : 0);
    mp = (p >= lim); pp = mp ? lim : p;
    return vv | (ms << 2) | (pp << 3) | (mp << 5);
  endfunction

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc = 0; lastWr = 0; gapCr = 0; gapEq = 0;
    sinkDefaults();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && txPattern == 0 && txSwing == 0 && txPreEmph == 0 && !crOk && !eqOk && !reqValid,
        "R1 reset state", {busy, txPattern, txSwing, crOk, eqOk}, 0);

    // immediate pass, 4 lanes
    sinkDefaults();
    runTrain(4);
    chk(crOk && eqOk, "R3 R4 pass both", {crOk, eqOk}, 3);
    chk(nWrites == 2 && wPat[0] == 1 && wPat[1] == 2, "R2 pattern writes", nWrites, 2);
    chk(wDrive[0] == 0, "R2 initial drive zero", wDrive[0], 0);
    chk(gapCr == CRW + 1, "R11 CR wait", gapCr, CRW + 1); // accept edge to read raise
    chk(gapEq == EQW + 1, "R11 EQ wait", gapEq, EQW + 1);
    chk(nReads == 2, "R14 status reads", nReads, 2);

    // R5 R6 R7 sweep on odd lane 1 with 2 lanes active
    for (int v = 0; v < 4; v++) begin
      for (int p = 0; p < 4; p++) begin
        sinkDefaults();
        crPassAfter = 1;
        reqV[1] = 2'(v); reqP[1] = 2'(p);
        runTrain(2);
        chk(nWrites == 3 && int'(wDrive[1]) == expDrive(v, p), "R5 R6 R7 adjusted drive",
            wDrive[1], expDrive(v, p));
        chk(crOk && eqOk && txSwing == 2'(expDrive(v, p) & 3), "R13 final drive held", txSwing,
            expDrive(v, p) & 3);
      end
    end

    // R8 max swing stop
    sinkDefaults();
    crPassAfter = 99; reqV[0] = 2'd3; reqP[0] = 2'd3;
    runTrain(1);
    chk(nReads == 2 && !crOk && !eqOk, "R8 max swing stop reads", nReads, 2);
    chk(wDrive[1] == 8'd46 && txSwing == 2 && txPreEmph == 1, "R8 clamped drive", wDrive[1], 46);
    chk(nWrites == 2 && wPat[1] == 1, "R12 no EQ after CR fail", nWrites, 2);

    // R9 same swing stop, swing 1 requested
    sinkDefaults();
    crPassAfter = 99; reqV[0] = 2'd1;
    runTrain(1);
    chk(nReads == 6 && !crOk, "R9 same swing 1 reads", nReads, 6);

    // R9 + R14 lane 3 stuck with 4 lanes, swing 0 requested
    sinkDefaults();
    crPassAfter = 0; stuck = 4'b1000;
    runTrain(4);
    chk(nReads == 5 && !crOk, "R9 R14 stuck lane 3 active", nReads, 5);
    sinkDefaults();
    stuck = 4'b1000;
    runTrain(2);
    chk(crOk && eqOk, "R14 stuck lane 3 inactive", {crOk, eqOk}, 3);

    // R14 lane 1 ignored with 1 lane
    sinkDefaults();
    stuck = 4'b0010; reqV[1] = 2'd3; reqP[1] = 2'd3;
    runTrain(1);
    chk(crOk && eqOk && txSwing == 0 && txPreEmph == 0, "R14 inactive lane ignored", txSwing, 0);
    sinkDefaults();
    stuck = 4'b0010; reqV[1] = 2'd3;
    runTrain(2);
    chk(!crOk && nReads == 2, "R14 R8 lane 1 active", nReads, 2);

    // R10 equalisation never passes
    sinkDefaults();
    eqPassAfter = 99;
    runTrain(2);
    chk(eqReads == 7 && crOk && !eqOk, "R10 EQ attempt limit", eqReads, 7);

    // R4 EQ passes after 3 failures
    sinkDefaults();
    eqPassAfter = 3;
    runTrain(4);
    chk(eqReads == 4 && eqOk, "R4 EQ late pass", eqReads, 4);

    // R5 adjust during EQ
    sinkDefaults();
    eqPassAfter = 1; reqV[0] = 2'd2; reqP[0] = 2'd2;
    runTrain(1);
    chk(nWrites == 3 && wDrive[2] == 8'd46 && wPat[2] == 2 && eqOk, "R5 EQ adjust", wDrive[2], 46);

    // R12 read failure in CR
    sinkDefaults();
    crPassAfter = 99; reqV[0] = 2'd1; failReadAt = 1;
    runTrain(1);
    chk(nReads == 2 && nWrites == 2 && !crOk && !eqOk, "R12 CR read abort", nReads, 2);

    // R12 write failure in EQ
    sinkDefaults();
    failWriteAt = 1;
    runTrain(4);
    chk(nReads == 1 && crOk && !eqOk, "R12 EQ write abort", nReads, 1);

    // R13 results stay while idle
    repeat (20) @(negedge clk);
    chk(crOk && !eqOk && !busy && !reqValid, "R13 idle hold", {crOk, eqOk}, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule